// File: doc/BRIEF.md
# Multiplexed-Bus Modem Register Interface

This block is the register-access front end of a modem peripheral. A microprocessor reaches it over an 8-bit multiplexed address/data bus. An address phase is marked by the latch strobe `ale`. The falling edge of `ale` captures a 3-bit register address and the level of the active-low select `cs_n`. Low-going `rd_n` and `wr_n` strobes then move a byte out of or into the selected register. The block holds four control registers, a tone register and a read-only detect register. Detect events enter as single-cycle pulses on `det_in`, are held as flags, and raise `irq`. Reading the detect register clears the flags.

All strobes pass through two-flop synchronizers, and their edges are found in the `clk` domain, so every register update is synchronous. The bus is split into `bus_in`, `bus_out` and an enable `bus_oe`, which drive the three-state pad outside this block. A serial control mode reuses the same pins: hold `ale` high and `cs_n` low, and the rising edges of `wr_n` then shift in data bits. A clock-output mux picks either the crystal clock or a 16x data-rate clock. The 16x clock is used only when a control bit asks for it and a phase or amplitude modulation mode is selected.

Top module: `mbus_regif`

## Requirements
- R1: On each falling edge of `ale`, the block captures `bus_in[2:0]` as the register address and captures `cs_n` as the latched select. Both are held until the next falling edge of `ale`, so later changes on the bus or on `cs_n` do not change which register a strobe reaches.
- R2: `bus_oe` is 1 only while synchronized `rd_n` is low, the latched select is low and serial mode is off. At all other times `bus_oe` is 0.
- R3: A rising edge of `wr_n` writes `bus_in` into the addressed register only when the latched select is low. When the latched select is high, the write leaves every register unchanged.
- R4: Any `det_in` pulse sets its flag, and `irq` goes to 1 in the cycle after the pulse. `irq` stays at 1 through reads of other registers until the detect register is read or reset is applied.
- R5: Reading address 4 returns the latched flags (bit i = `det_in[i]` seen). All flags clear in the cycle the read completes, which is the rising edge of `rd_n`. A flag whose pulse arrives in that same cycle is kept.
- R6: Reset (`rst` high) clears control registers 0 to 3, the tone register and all detect flags. With control register 1 cleared, `clk_out` follows `xtal_in`.
- R7: `clk_out` follows `baud16_in` only when control register 1 bit 7 is 1 and control register 0 bits [1:0] are 01 (DPSK) or 10 (QAM). For codes 00 (FSK) and 11 (tone), or when the bit is 0, `clk_out` follows `xtal_in`.
- R8: The address map is: control registers 0 to 3 at addresses 0 to 3, detect at 4, tone at 5. Writes to 4, 6 and 7 change nothing. Reads of 6 and 7 return 0.
- R9: Serial mode is on while synchronized `ale` is high and `cs_n` is low. Each rising edge of `wr_n` then shifts in `bus_in[7]`, most significant bit first. The eighth edge writes the byte to the address on `bus_in[2:0]` at that edge. In serial mode parallel writes do not occur and `bus_oe` stays at 0.
- R10: Leaving serial mode before the eighth bit discards the partial byte. The next serial frame starts from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high asynchronous reset |
| ale | input | 1 | Address latch strobe; falling edge captures address and select |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe; also the serial shift clock |
| bus_in | input | 8 | Bus value seen at the pads |
| bus_out | output | 8 | Read data toward the pads |
| bus_oe | output | 1 | Pad drive enable |
| det_in | input | 8 | Detect event pulses |
| irq | output | 1 | Interrupt, high while any detect flag is set |
| xtal_in | input | 1 | Crystal clock |
| baud16_in | input | 1 | 16x data-rate clock |
| clk_out | output | 1 | Selected output clock |

## Verification
Parallel writes and reads are tried with the select latched low and with it latched high. In the high case `cs_n` is pulled low after the latch, which shows whether the latched level or the live level gates the access. The bus is also changed between the address phase and the strobe, which shows that the address is latched and not sampled live. Detect pulses are tested three ways: arriving long before a read, checked across reads of other registers, and landing in exactly the cycle a detect read completes. Together these separate snapshot-and-clear from clear-everything. Serial frames are sent both whole and abandoned part-way, which shows whether the bit counter restarts. All four modulation codes are crossed with the clock-select bit.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int unsigned DW     = 8;
  localparam int unsigned AW     = 3;
  localparam int unsigned NCTRL  = 4;
  localparam logic [AW-1:0] ADDR_DET  = 3'd4;
  localparam logic [AW-1:0] ADDR_TONE = 3'd5;

  typedef enum logic [1:0] {
    MOD_FSK  = 2'b00,
    MOD_DPSK = 2'b01,
    MOD_QAM  = 2'b10,
    MOD_TONE = 2'b11
  } mod_e;

  // True when the fast data-rate clock may drive the clock output.
  function automatic logic pick_baud_clk(input logic [DW-1:0] c0, input logic [DW-1:0] c1);
    mod_e m;
    m = mod_e'(c0[1:0]);
    return c1[7] && (m == MOD_DPSK || m == MOD_QAM);
  endfunction

  // Flag update: clear on completed detect read, but keep same-cycle arrivals.
  function automatic logic [DW-1:0] next_flags(input logic [DW-1:0] cur,
                                               input logic clr,
                                               input logic [DW-1:0] pulses);
    return (clr ? '0 : cur) | pulses;
  endfunction
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or posedge rst) begin
        if (rst) chain[s] <= INIT;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbus_serial_rx.sv
module mbus_serial_rx
  import mbus_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          shift_evt,
  input  logic          bit_in,
  input  logic [AW-1:0] addr_in,
  output logic          wr_evt,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int unsigned CW = $clog2(DW);

  logic [DW-2:0] shreg;
  logic [CW-1:0] cnt;
  logic          last_bit;

  assign last_bit = (cnt == CW'(DW-1));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      shreg   <= '0;
      cnt     <= '0;
      wr_evt  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_evt <= 1'b0;
      if (!active) begin
        cnt <= '0;
      end else if (shift_evt) begin
        shreg <= {shreg[DW-3:0], bit_in};
        cnt   <= last_bit ? '0 : cnt + 1'b1;
        if (last_bit) begin
          wr_evt  <= 1'b1;
          wr_addr <= addr_in;
          wr_data <= {shreg, bit_in};
        end
      end
    end
  end
endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile
  import mbus_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic [AW-1:0]       rd_addr,
  input  logic                det_clr,
  input  logic [DW-1:0]       det_in,
  output logic [DW-1:0]       rd_data,
  output logic [NCTRL*DW-1:0] ctrl_flat,
  output logic [DW-1:0]       tone_q,
  output logic                irq
);
  logic [DW-1:0] ctrl_q [NCTRL];
  logic [DW-1:0] flags_q;

  generate
    for (genvar i = 0; i < NCTRL; i++) begin : g_ctrl
      always_ff @(posedge clk or posedge rst) begin
        if (rst) ctrl_q[i] <= '0;
        else if (wr_en && wr_addr == AW'(i)) ctrl_q[i] <= wr_data;
      end
      assign ctrl_flat[i*DW +: DW] = ctrl_q[i];
    end
  endgenerate

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      tone_q  <= '0;
      flags_q <= '0;
    end else begin
      if (wr_en && wr_addr == ADDR_TONE) tone_q <= wr_data;
      flags_q <= next_flags(flags_q, det_clr, det_in);
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr < AW'(NCTRL)) rd_data = ctrl_q[rd_addr[1:0]];
    else if (rd_addr == ADDR_DET) rd_data = flags_q;
    else if (rd_addr == ADDR_TONE) rd_data = tone_q;
  end

  assign irq = |flags_q;
endmodule

// File: rtl/mbus_regif.sv
module mbus_regif
  import mbus_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          ale,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  input  logic [DW-1:0] det_in,
  output logic          irq,
  input  logic          xtal_in,
  input  logic          baud16_in,
  output logic          clk_out
);
  // synchronized strobes: {ale, cs_n, rd_n, wr_n}
  logic [3:0] strb_s, strb_d;
  logic ale_s, cs_s, rd_s, wr_s;
  logic ale_fall, rd_rise, wr_rise;
  logic ser_mode;
  logic [AW-1:0] addr_q;
  logic cs_lat_n;
  logic par_wr, ser_wr, any_wr, det_rd_done;
  logic [AW-1:0] ser_addr, any_addr;
  logic [DW-1:0] ser_data, any_data, rd_data;
  logic [NCTRL*DW-1:0] ctrl_flat;
  logic [DW-1:0] tone_q;

  mbus_sync #(.W(4), .STAGES(2), .INIT(4'b0111)) u_sync (
    .clk(clk), .rst(rst), .d({ale, cs_n, rd_n, wr_n}), .q(strb_s)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) strb_d <= 4'b0111;
    else     strb_d <= strb_s;
  end

  assign {ale_s, cs_s, rd_s, wr_s} = strb_s;
  assign ale_fall = strb_d[3] && !ale_s;
  assign rd_rise  = !strb_d[1] && rd_s;
  assign wr_rise  = !strb_d[0] && wr_s;
  assign ser_mode = ale_s && !cs_s;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      addr_q   <= '0;
      cs_lat_n <= 1'b1;
    end else if (ale_fall) begin
      addr_q   <= bus_in[AW-1:0];
      cs_lat_n <= cs_s;
    end
  end

  mbus_serial_rx u_ser (
    .clk(clk), .rst(rst), .active(ser_mode), .shift_evt(wr_rise),
    .bit_in(bus_in[DW-1]), .addr_in(bus_in[AW-1:0]),
    .wr_evt(ser_wr), .wr_addr(ser_addr), .wr_data(ser_data)
  );

  assign par_wr   = wr_rise && !cs_lat_n && !ser_mode;
  assign any_wr   = par_wr || ser_wr;
  assign any_addr = ser_wr ? ser_addr : addr_q;
  assign any_data = ser_wr ? ser_data : bus_in;
  assign det_rd_done = rd_rise && !cs_lat_n && !ser_mode && addr_q == ADDR_DET;

  mbus_regfile u_rf (
    .clk(clk), .rst(rst), .wr_en(any_wr), .wr_addr(any_addr), .wr_data(any_data),
    .rd_addr(addr_q), .det_clr(det_rd_done), .det_in(det_in),
    .rd_data(rd_data), .ctrl_flat(ctrl_flat), .tone_q(tone_q), .irq(irq)
  );

  assign bus_oe  = !rd_s && !cs_lat_n && !ser_mode;
  assign bus_out = bus_oe ? rd_data : '0;
  assign clk_out = pick_baud_clk(ctrl_flat[DW-1:0], ctrl_flat[2*DW-1:DW]) ? baud16_in : xtal_in;
endmodule

// File: rtl/mbus_regif_chk.sv
module mbus_regif_chk
  import mbus_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                bus_oe,
  input logic                cs_lat_n,
  input logic                ser_mode,
  input logic                wr_rise,
  input logic                det_rd_done,
  input logic [DW-1:0]       det_in,
  input logic                irq,
  input logic [NCTRL*DW-1:0] ctrl_flat,
  input logic [DW-1:0]       tone_q,
  input logic                clk_out,
  input logic                xtal_in
);
  // R2
  oe_gated_chk: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> (!cs_lat_n && !ser_mode));

  // R3
  unselected_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_rise && cs_lat_n && !ser_mode) |=> ($stable(ctrl_flat) && $stable(tone_q)));

  // R4
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (|det_in) |=> irq);

  // R5
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (det_rd_done && det_in == '0) |=> !irq);

  // R6
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (ctrl_flat == '0 && tone_q == '0 && !irq));

  // R7
  xtal_default_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_flat[2*DW-1] |-> (clk_out == xtal_in));
endmodule

bind mbus_regif mbus_regif_chk chk_i (
  .clk(clk), .rst(rst), .bus_oe(bus_oe), .cs_lat_n(cs_lat_n), .ser_mode(ser_mode),
  .wr_rise(wr_rise), .det_rd_done(det_rd_done), .det_in(det_in), .irq(irq),
  .ctrl_flat(ctrl_flat), .tone_q(tone_q), .clk_out(clk_out), .xtal_in(xtal_in)
);

// File: tb/mbus_regif_tb_top.sv
module mbus_regif_tb_top;
  logic clk = 0, rst = 1;
  logic ale = 0, cs_n = 1, rd_n = 1, wr_n = 1;
  logic [7:0] bus_in = 0, det_in = 0;
  logic xtal_in = 0, baud16_in = 1;
  logic [7:0] bus_out;
  logic bus_oe, irq, clk_out;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mbus_regif dut_i (
    .clk(clk), .rst(rst), .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .det_in(det_in),
    .irq(irq), .xtal_in(xtal_in), .baud16_in(baud16_in), .clk_out(clk_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic addr_phase(input logic [2:0] a, input logic cs);
    ale = 1; cs_n = cs; bus_in = {5'b0, a}; waitn(5);
    ale = 0; waitn(5);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d, input logic cs);
    addr_phase(a, cs);
    cs_n = 0; bus_in = d; wr_n = 0; waitn(5);
    wr_n = 1; waitn(5); cs_n = 1;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d, output logic oe);
    addr_phase(a, 0);
    bus_in = 8'hA5; rd_n = 0; waitn(5);
    d = bus_out; oe = bus_oe;
    rd_n = 1; waitn(5); cs_n = 1;
  endtask

  task automatic t_reset();
    chk(bus_oe == 0, "R6 oe after reset", bus_oe, 0);
    chk(irq == 0, "R6 irq after reset", irq, 0);
    xtal_in = 1; baud16_in = 0; waitn(1);
    chk(clk_out == 1, "R6 crystal selected", clk_out, 1);
  endtask

  task automatic t_regs();
    logic [7:0] d; logic oe;
    for (int i = 0; i < 4; i++) bus_write(3'(i), 8'h10 + 8'(i*17), 0);
    bus_write(3'd5, 8'h5C, 0);
    for (int i = 0; i < 4; i++) begin
      bus_read(3'(i), d, oe);
      chk(oe && d == 8'h10 + 8'(i*17), "R3 R8 ctrl readback", d, 8'h10 + i*17);
    end
    bus_read(3'd5, d, oe);
    chk(d == 8'h5C, "R8 tone readback", d, 8'h5C);
    bus_write(3'd4, 8'hFF, 0);
    bus_write(3'd6, 8'hFF, 0);
    bus_read(3'd4, d, oe);
    chk(d == 0 && irq == 0, "R8 detect write ignored", d, 0);
    bus_read(3'd6, d, oe);
    chk(d == 0, "R8 unused addr reads zero", d, 0);
    bus_read(3'd7, d, oe);
    chk(d == 0, "R8 unused addr 7 reads zero", d, 0);
  endtask

  task automatic t_select();
    logic [7:0] d; logic oe;
    bus_write(3'd2, 8'hEE, 1);
    bus_read(3'd2, d, oe);
    chk(d == 8'h32, "R1 R3 latched cs high blocks write", d, 8'h32);
    addr_phase(3'd0, 1);
    cs_n = 0; rd_n = 0; waitn(5);
    chk(bus_oe == 0, "R2 no drive with latched cs high", bus_oe, 0);
    rd_n = 1; waitn(5);
    chk(bus_oe == 0, "R2 no drive with rd high", bus_oe, 0);
    addr_phase(3'd3, 0);
    bus_in = 8'h01; rd_n = 0; waitn(5);
    chk(bus_out == 8'h43, "R1 address held after bus change", bus_out, 8'h43);
    rd_n = 1; waitn(5);
  endtask

  task automatic t_detect();
    logic [7:0] d; logic oe;
    det_in = 8'h12; waitn(1); det_in = 0; waitn(1);
    chk(irq == 1, "R4 irq raised", irq, 1);
    bus_read(3'd1, d, oe);
    chk(irq == 1, "R4 irq held over other read", irq, 1);
    bus_read(3'd4, d, oe);
    chk(d == 8'h12, "R5 detect snapshot", d, 8'h12);
    chk(irq == 0, "R5 irq cleared by detect read", irq, 0);
    addr_phase(3'd4, 0);
    rd_n = 0; waitn(5);
    rd_n = 1; waitn(2);
    det_in = 8'h80; waitn(1); det_in = 0; waitn(4);
    chk(irq == 1, "R5 same-cycle flag kept", irq, 1);
    bus_read(3'd4, d, oe);
    chk(d == 8'h80, "R5 kept flag value", d, 8'h80);
    det_in = 8'h01; waitn(1); det_in = 0;
    rst = 1; waitn(2); rst = 0; waitn(2);
    chk(irq == 0, "R6 reset clears flags", irq, 0);
  endtask

  task automatic t_clock();
    xtal_in = 0; baud16_in = 1;
    for (int m = 0; m < 4; m++) begin
      bus_write(3'd0, 8'(m), 0);
      bus_write(3'd1, 8'h80, 0);
      chk(clk_out == (m == 1 || m == 2), "R7 mode with select set", clk_out, (m == 1 || m == 2));
      bus_write(3'd1, 8'h00, 0);
      chk(clk_out == 0, "R7 select clear gives crystal", clk_out, 0);
    end
  endtask

  task automatic ser_bits(input logic [7:0] d, input int n, input logic [2:0] a);
    for (int i = 0; i < n; i++) begin
      bus_in = {d[7-i], 4'b0, a}; wr_n = 0; waitn(4);
      wr_n = 1; waitn(4);
    end
  endtask

  task automatic t_serial();
    logic [7:0] d; logic oe;
    ale = 1; cs_n = 0; waitn(5);
    rd_n = 0; waitn(5);
    chk(bus_oe == 0, "R9 no drive in serial mode", bus_oe, 0);
    rd_n = 1; waitn(5);
    ser_bits(8'hB6, 8, 3'd5);
    ale = 0; waitn(5);
    bus_read(3'd5, d, oe);
    chk(d == 8'hB6, "R9 serial write to tone", d, 8'hB6);
    ale = 1; cs_n = 0; waitn(5);
    ser_bits(8'hFF, 3, 3'd2);
    ale = 0; waitn(5);
    ale = 1; cs_n = 0; waitn(5);
    ser_bits(8'h69, 8, 3'd2);
    ale = 0; waitn(5);
    bus_read(3'd2, d, oe);
    chk(d == 8'h69, "R10 partial frame discarded", d, 8'h69);
  endtask

  initial begin
    waitn(3); rst = 0; waitn(3);
    t_reset();
    t_regs();
    t_select();
    t_detect();
    t_clock();
    t_serial();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule